// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order integer pipeline and supplies the two source operands of the instruction being decoded. Each operand can come from one of four places: the register file read port, the ALU result of the instruction now in execute (taken live, before the EX/MEM register), the result held in the memory stage, or the data being written back. The choice is made by comparing the decoding instruction's two source addresses with the destination address and write enable that travel with each older instruction in EX, MEM and WB.

The choice is made one stage earlier than in an execute-stage scheme. An early branch comparator in decode can therefore use the bypassed operands in the same cycle. The same operands are captured into the ID/EX operand register at the next rising edge. The write-back bypass means the register file does not have to write before it reads. Address 0 is hard-wired to zero and is never taken from a bypass path.

Top module: `dec_fwd_unit`

## Requirements
- R1: When the EX-stage instruction has its write enable set and its destination equals a non-zero source address, that operand takes the live EX ALU value, with select code 01. This wins over MEM and WB.
- R2: When EX does not match, and the MEM-stage instruction has its write enable set and its destination equals the non-zero source address, the operand takes the MEM value, with select code 10. This wins over WB.
- R3: When neither EX nor MEM matches, and the WB-stage instruction has its write enable set and its destination equals the non-zero source address, the operand takes the write-back data, with select code 11. This replaces the stale register file output.
- R4: A source address of 0 always gives the operand value zero with select code 00. This holds whatever the register file data is and even if a stage writes destination 0 with its enable set.
- R5: A stage whose write enable is low is never forwarded from, even if its destination address matches.
- R6: When no stage qualifies, the operand is the register file read data, with select code 00.
- R7: The select codes are 00 register file, 01 EX, 10 MEM and 11 WB. Both the codes and the operands are combinational in the same cycle as the addresses.
- R8: On each rising clock edge the ID/EX operand outputs capture the two selected operands. A synchronous active-high reset clears them to zero.
- R9: The two operands are resolved independently. When both source addresses name the same register, both get the same select code and value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_addr | input | AW | First source address of the decoding instruction |
| rt_addr | input | AW | Second source address of the decoding instruction |
| rf_rs_data | input | DW | Register file read data for rs_addr |
| rf_rt_data | input | DW | Register file read data for rt_addr |
| ex_rd | input | AW | Destination of the instruction in EX |
| ex_wen | input | 1 | Register write enable of the instruction in EX |
| ex_alu | input | DW | Live ALU output in EX (before the EX/MEM register) |
| mem_rd | input | AW | Destination of the instruction in MEM |
| mem_wen | input | 1 | Register write enable of the instruction in MEM |
| mem_val | input | DW | Result held in the MEM stage |
| wb_rd | input | AW | Destination of the instruction in WB |
| wb_wen | input | 1 | Register write enable of the instruction in WB |
| wb_data | input | DW | Write-back data |
| op_a | output | DW | Selected first operand (to branch compare) |
| op_b | output | DW | Selected second operand (to branch compare) |
| sel_a | output | 2 | Select code for op_a |
| sel_b | output | 2 | Select code for op_b |
| idex_a | output | DW | First operand registered into ID/EX |
| idex_b | output | DW | Second operand registered into ID/EX |

## Verification
The select codes and the selected operands must be valid in the same cycle as the addresses and data are presented. The bench therefore drives new inputs just after a falling edge and samples them one time unit later, before any rising edge. The ID/EX outputs are one register later: the values expected for one decode slot are kept and compared at the next falling edge, after the intervening rising edge has captured them. The expected operand is the register's value in a sequential, in-order model of the program. This value does not depend on which path the design picks, so a wrong priority or a missed bypass appears as a value mismatch as well as a select mismatch.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_EX  = 2'b01,
    SEL_MEM = 2'b10,
    SEL_WB  = 2'b11
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/fwd_match.sv
// Per-operand hazard comparator: nearest qualifying producer wins.
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);
  logic src_nz;
  logic hit_ex, hit_mem, hit_wb;

  assign src_nz  = |src;
  assign hit_ex  = src_nz && ex_wen  && (ex_rd  == src);
  assign hit_mem = src_nz && mem_wen && (mem_rd == src);
  assign hit_wb  = src_nz && wb_wen  && (wb_rd  == src);

  always_comb begin
    if (hit_ex)       sel = SEL_EX;
    else if (hit_mem) sel = SEL_MEM;
    else if (hit_wb)  sel = SEL_WB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_mux.sv
// Operand mux; the register-file path yields zero for address 0.
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  fwd_sel_e      sel,
  input  logic          src_zero,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] ex_val,
  input  logic [DW-1:0] mem_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] out
);
  always_comb begin
    unique case (sel)
      SEL_EX:  out = ex_val;
      SEL_MEM: out = mem_val;
      SEL_WB:  out = wb_val;
      default: out = src_zero ? '0 : rf_val;
    endcase
  end
endmodule

// File: rtl/dec_fwd_unit.sv
module dec_fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rs_addr,
  input  logic [AW-1:0] rt_addr,
  input  logic [DW-1:0] rf_rs_data,
  input  logic [DW-1:0] rf_rt_data,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [DW-1:0] ex_alu,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [DW-1:0] mem_val,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic [DW-1:0] wb_data,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] idex_a,
  output logic [DW-1:0] idex_b
);
  logic [AW-1:0] src   [NUM_SRC];
  logic [DW-1:0] rfv   [NUM_SRC];
  logic [DW-1:0] opv   [NUM_SRC];
  fwd_sel_e      selv  [NUM_SRC];
  logic [DW-1:0] idexv [NUM_SRC];

  assign src[0] = rs_addr;
  assign src[1] = rt_addr;
  assign rfv[0] = rf_rs_data;
  assign rfv[1] = rf_rt_data;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_port
    fwd_match #(.AW(AW)) u_match (
      .src     (src[g]),
      .ex_rd   (ex_rd),
      .ex_wen  (ex_wen),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (selv[g])
    );

    fwd_mux #(.DW(DW)) u_mux (
      .sel      (selv[g]),
      .src_zero (src[g] == '0),
      .rf_val   (rfv[g]),
      .ex_val   (ex_alu),
      .mem_val  (mem_val),
      .wb_val   (wb_data),
      .out      (opv[g])
    );

    always_ff @(posedge clk) begin
      if (rst) idexv[g] <= '0;
      else     idexv[g] <= opv[g];
    end
  end

  assign op_a   = opv[0];
  assign op_b   = opv[1];
  assign sel_a  = selv[0];
  assign sel_b  = selv[1];
  assign idex_a = idexv[0];
  assign idex_b = idexv[1];

  // Assertions
  p_ex_first_r1: assert property (@(posedge clk) disable iff (rst)
    (ex_wen && rs_addr != '0 && ex_rd == rs_addr) |-> (sel_a == 2'b01 && op_a == ex_alu));

  p_mem_over_wb_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_wen && rt_addr != '0 && mem_rd == rt_addr && !(ex_wen && ex_rd == rt_addr))
      |-> (sel_b == 2'b10 && op_b == mem_val));

  p_wb_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (wb_wen && rt_addr != '0 && wb_rd == rt_addr && !(ex_wen && ex_rd == rt_addr)
      && !(mem_wen && mem_rd == rt_addr)) |-> (op_b == wb_data));

  p_zero_src_r4: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == '0) |-> (sel_a == 2'b00 && op_a == '0));

  p_no_enable_r5: assert property (@(posedge clk) disable iff (rst)
    (!ex_wen && !mem_wen && !wb_wen && rt_addr != '0) |-> (sel_b == 2'b00 && op_b == rf_rt_data));

  p_capture_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (idex_a == $past(op_a) && idex_b == $past(op_b)));

  p_same_src_r9: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == rt_addr) |-> (sel_a == sel_b && op_a == op_b));
endmodule

// File: tb/dec_fwd_unit_tb.sv
module dec_fwd_unit_tb;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rs_addr = '0, rt_addr = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic [DW-1:0] rf_rs_data = '0, rf_rt_data = '0, ex_alu = '0, mem_val = '0, wb_data = '0;
  logic          ex_wen = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
  logic [DW-1:0] op_a, op_b, idex_a, idex_b;
  logic [1:0]    sel_a, sel_b;

  always #5 clk = ~clk;

  dec_fwd_unit #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .rs_addr(rs_addr), .rt_addr(rt_addr),
    .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_alu(ex_alu),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_val(mem_val),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_data(wb_data),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b),
    .idex_a(idex_a), .idex_b(idex_b)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state: register file, sequential architectural values, stage slots
  logic [DW-1:0] rf   [32];
  logic [DW-1:0] gold [32];
  logic [AW-1:0] slot_rd  [3];   // 0 = EX, 1 = MEM, 2 = WB
  logic          slot_wen [3];
  logic [DW-1:0] slot_val [3];
  logic [AW-1:0] pend_rd;
  logic          pend_wen;
  logic [DW-1:0] pend_val;
  logic [DW-1:0] prev_a = '0, prev_b = '0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
    if (s == 0) return 2'b00;
    for (int k = 0; k < 3; k++)
      if (slot_wen[k] && slot_rd[k] == s) return 2'(k + 1);
    return 2'b00;
  endfunction

  function automatic string tag(input logic [AW-1:0] s, input logic [1:0] e, input bit same);
    string t;
    case (e)
      2'b01: t = "R1";
      2'b10: t = "R2";
      2'b11: t = "R3";
      default: t = (s == 0) ? "R4" : "R6";
    endcase
    for (int k = 0; k < 3; k++)
      if (!slot_wen[k] && slot_rd[k] == s && s != 0) t = {t, "/R5"};
    if (same) t = {t, "/R9"};
    return {t, "/R7"};
  endfunction

  function automatic logic [DW-1:0] alu(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic step(input int op, input logic [AW-1:0] rd, input logic [AW-1:0] rs,
                      input logic [AW-1:0] rt, input logic wen);
    logic [DW-1:0] ea, eb;
    logic [1:0] sa, sb;
    @(negedge clk);
    check("R8 idex_a", idex_a, prev_a);
    check("R8 idex_b", idex_b, prev_b);
    // retire WB into register file, advance the pipeline
    if (slot_wen[2] && slot_rd[2] != 0) rf[slot_rd[2]] = slot_val[2];
    for (int k = 2; k > 0; k--) begin
      slot_rd[k] = slot_rd[k-1]; slot_wen[k] = slot_wen[k-1]; slot_val[k] = slot_val[k-1];
    end
    slot_rd[0] = pend_rd; slot_wen[0] = pend_wen; slot_val[0] = pend_val;
    // expected operands from the in-order program
    ea = (rs == 0) ? '0 : gold[rs];
    eb = (rt == 0) ? '0 : gold[rt];
    sa = ref_sel(rs);
    sb = ref_sel(rt);
    pend_rd = rd; pend_wen = wen;
    pend_val = wen ? alu(op, ea, eb) : $urandom();
    if (wen && rd != 0) gold[rd] = pend_val;
    // drive
    rs_addr = rs; rt_addr = rt;
    rf_rs_data = (rs == 0) ? 32'hDEAD_BEEF : rf[rs];
    rf_rt_data = (rt == 0) ? 32'hDEAD_BEEF : rf[rt];
    ex_rd = slot_rd[0];  ex_wen = slot_wen[0];  ex_alu = slot_val[0];
    mem_rd = slot_rd[1]; mem_wen = slot_wen[1]; mem_val = slot_val[1];
    wb_rd = slot_rd[2];  wb_wen = slot_wen[2];  wb_data = slot_val[2];
    #1;
    check({tag(rs, sa, rs == rt), " sel_a"}, DW'(sel_a), DW'(sa));
    check({tag(rt, sb, rs == rt), " sel_b"}, DW'(sel_b), DW'(sb));
    check({tag(rs, sa, rs == rt), " op_a"}, op_a, ea);
    check({tag(rt, sb, rs == rt), " op_b"}, op_b, eb);
    prev_a = ea; prev_b = eb;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i] = (i == 0) ? '0 : DW'(i * 32'h0101_0111 + 3);
      gold[i] = rf[i];
    end
    for (int k = 0; k < 3; k++) begin
      slot_rd[k] = '0; slot_wen[k] = 1'b0; slot_val[k] = '0;
    end
    pend_rd = '0; pend_wen = 1'b0; pend_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset idex_a", idex_a, '0);
    check("R8 reset idex_b", idex_b, '0);
    rst = 1'b0;
    // dependent chain: and r4,r3,r1 / or r8,r1,r4 / sub r3,r4,r4 / add r5,r4,r3 / and r1,r6,r7
    step(2, 5'd4, 5'd3, 5'd1, 1'b1);
    step(3, 5'd8, 5'd1, 5'd4, 1'b1);   // R1 on rt
    step(1, 5'd3, 5'd4, 5'd4, 1'b1);   // R2 on both, R9
    step(0, 5'd5, 5'd4, 5'd3, 1'b1);   // R3 on rs, R1 on rt
    step(2, 5'd1, 5'd6, 5'd7, 1'b1);   // R6
    step(0, 5'd0, 5'd5, 5'd5, 1'b1);   // writes r0
    step(0, 5'd2, 5'd0, 5'd0, 1'b1);   // R4: r0 writer in EX ignored
    step(0, 5'd2, 5'd1, 5'd3, 1'b0);   // non-writing, rd=r2
    step(0, 5'd9, 5'd2, 5'd2, 1'b1);   // R5: disabled match in EX
    for (int n = 0; n < 400; n++)
      step(int'($urandom_range(0, 3)), AW'($urandom_range(0, 7)), AW'($urandom_range(0, 7)),
           AW'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0));
    step(0, 5'd0, 5'd0, 5'd0, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule